// File: doc/BRIEF.md
# Multi-Mode Operand Locator

This block turns one instruction's addressing information into an effective address and an operand value. The inputs are a 4-bit mode code, an address or displacement field, a register selector, a pointer depth and the current program counter. The block reads the register file through a combinational read port that it drives but never writes. It reaches memory through a synchronous read port. Data returns one clock after the read is issued.

Some modes finish without any memory traffic. Others chase one or more pointers before they fetch the operand, so the latency depends on the mode. A request is taken only while the block is idle. The result appears together with a one-cycle `done` strobe. Codes outside the defined set end at once with an error flag.

Top module: `operand_locator`

## Requirements
- R1: After reset `done` and `err` are 0, `idle` is 1 and no memory read is issued until a request is accepted.
- R2: Mode code 0 (immediate) returns operand = field and EA = field, with no memory read.
- R3: Mode code 3 (register) returns operand = reg[sel] and EA = sel zero-extended, with no memory read.
- R4: Mode code 1 (direct) gives EA = field and operand = mem[EA], using exactly one memory read.
- R5: Mode code 2 (memory-indirect) follows a chain of pointers. The chain starts at the field and is d links long, where d is the depth input (1 to 3, with 0 treated as 1). It then reads the operand at the final pointer, for d+1 reads in total.
- R6: Mode code 4 (register-indirect) gives EA = reg[sel] and operand = mem[EA], using one memory read.
- R7: Mode code 5 (displacement) gives EA = field + reg[sel]. Mode code 6 (PC-relative) gives EA = field + pc, with pc sampled when the request is accepted. Both sums wrap modulo 2^W and need one read.
- R8: Mode code 7 (post-indexed) gives EA = mem[field] + reg[sel]. Mode code 8 (pre-indexed) gives EA = mem[field + reg[sel]]. Each uses two reads, and operand = mem[EA].
- R9: Mode code 9 (stack) takes reg[sel] as the stack pointer and reports it as EA. It pops two entries: operand = mem[sp] and the second operand = mem[sp+1], using two reads. In every other mode the second operand is 0.
- R10: Codes 10 to 15 end with `err` high together with `done`, EA = 0, operand = 0 and no memory read.
- R11: `done` is a one-cycle pulse that rises 1 + (number of reads) clock edges after the accepting edge. `idle` is low from acceptance until `done`. A request presented while the block is busy is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_mode | input | 4 | Addressing mode code |
| req_field | input | W | Address, displacement or immediate field |
| req_sel | input | S | Register selector |
| req_depth | input | 2 | Pointer chain length for memory-indirect mode |
| pc | input | W | Current program counter |
| rf_sel | output | S | Register file read selector |
| rf_data | input | W | Register file read data (combinational) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | W | Memory read address |
| mem_rd_data | input | W | Memory read data, valid one cycle after the strobe |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal mode, valid with done |
| ea | output | W | Effective address |
| opnd | output | W | Operand value |
| opnd_b | output | W | Second stack operand |
| idle | output | 1 | Ready to accept a request |

## Verification
The bench targets pointer chains of every depth, including depth 0. A design that miscounts links would return the wrong EA and show one read too many or too few. Post-indexed and pre-indexed are run side by side, because adding the index on the wrong side of the dereference gives a valid-looking but wrong address. Address sums are pushed past the top of the address space to expose a missing wraparound. A second request is injected while the block is busy: a design that accepts it would either corrupt the result or emit a second `done`. The bench also varies pc after acceptance to catch a relative mode that does not hold the pc value sampled at acceptance.

// File: rtl/opl_pkg.sv
`timescale 1ns/1ps
package opl_pkg;
  localparam int DEPTH_W = 2;

  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_IND  = 4'd2,
    M_REG  = 4'd3,
    M_RIND = 4'd4,
    M_DISP = 4'd5,
    M_REL  = 4'd6,
    M_POST = 4'd7,
    M_PRE  = 4'd8,
    M_STK  = 4'd9
  } opl_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CALC, S_PTR, S_OPND, S_STK, S_STK2
  } opl_state_e;

  // chain length seen by the sequencer: depth 0 behaves as 1
  function automatic logic [DEPTH_W-1:0] eff_depth(input logic [DEPTH_W-1:0] d);
    return (d == '0) ? DEPTH_W'(1) : d;
  endfunction

  // modes whose first read returns a pointer rather than the operand
  function automatic logic walks_pointer(input logic [3:0] m);
    return (m == M_IND) || (m == M_POST) || (m == M_PRE);
  endfunction
endpackage

// File: rtl/opl_agu.sv
`timescale 1ns/1ps
module opl_agu #(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] field,
  input  logic [W-1:0] rdat,
  input  logic [W-1:0] pc_s,
  input  logic [W-1:0] mdat,
  output logic [W-1:0] first_addr,
  output logic [W-1:0] ptr_next
);
  import opl_pkg::*;

  function automatic logic [W-1:0] add_w(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  always_comb begin
    case (mode)
      M_RIND, M_STK: first_addr = rdat;
      M_DISP, M_PRE: first_addr = add_w(field, rdat);
      M_REL:         first_addr = add_w(field, pc_s);
      default:       first_addr = field;
    endcase
  end

  // index is applied after the dereference only in post-indexed mode
  assign ptr_next = (mode == M_POST) ? add_w(mdat, rdat) : mdat;
endmodule

// File: rtl/opl_ctrl.sv
`timescale 1ns/1ps
module opl_ctrl #(
  parameter int W = 16,
  parameter int S = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [3:0]                  req_mode,
  input  logic [W-1:0]                req_field,
  input  logic [S-1:0]                req_sel,
  input  logic [opl_pkg::DEPTH_W-1:0] req_depth,
  input  logic [W-1:0]                pc,
  input  logic [W-1:0]                rf_data,
  input  logic [W-1:0]                mem_rd_data,
  input  logic [W-1:0]                first_addr,
  input  logic [W-1:0]                ptr_next,
  output logic [3:0]                  cur_mode,
  output logic [W-1:0]                cur_field,
  output logic [W-1:0]                cur_pc,
  output logic [S-1:0]                cur_sel,
  output logic                        mem_rd_en,
  output logic [W-1:0]                mem_rd_addr,
  output logic                        done,
  output logic                        err,
  output logic [W-1:0]                ea,
  output logic [W-1:0]                opnd,
  output logic [W-1:0]                opnd_b,
  output logic                        idle
);
  import opl_pkg::*;

  opl_state_e           state_q, state_d;
  logic [3:0]           mode_q;
  logic [W-1:0]         field_q, pc_q, track_q, track_d, aux_q, aux_d;
  logic [S-1:0]         sel_q;
  logic [DEPTH_W-1:0]   left_q, left_d, dep_q;
  logic [2:0]           rdcnt_q;
  logic                 accept, fin, fin_err;
  logic [W-1:0]         fin_ea, fin_op, fin_opb;

  assign accept    = req_valid && (state_q == S_IDLE);
  assign idle      = (state_q == S_IDLE);
  assign cur_mode  = mode_q;
  assign cur_field = field_q;
  assign cur_pc    = pc_q;
  assign cur_sel   = sel_q;

  always_comb begin
    state_d = state_q;
    left_d = left_q;
    track_d = track_q;
    aux_d = aux_q;
    mem_rd_en = 1'b0;
    mem_rd_addr = '0;
    fin = 1'b0;
    fin_err = 1'b0;
    fin_ea = '0;
    fin_op = '0;
    fin_opb = '0;
    case (state_q)
      S_IDLE: if (accept) state_d = S_CALC;
      S_CALC: begin
        case (mode_q)
          M_IMM: begin fin = 1'b1; fin_ea = field_q; fin_op = field_q; end
          M_REG: begin fin = 1'b1; fin_ea = W'(sel_q); fin_op = rf_data; end
          M_DIR, M_RIND, M_DISP, M_REL: begin
            mem_rd_en = 1'b1; mem_rd_addr = first_addr;
            track_d = first_addr; state_d = S_OPND;
          end
          M_IND, M_POST, M_PRE: begin
            mem_rd_en = 1'b1; mem_rd_addr = first_addr; state_d = S_PTR;
          end
          M_STK: begin
            mem_rd_en = 1'b1; mem_rd_addr = first_addr;
            track_d = first_addr; state_d = S_STK;
          end
          default: begin fin = 1'b1; fin_err = 1'b1; end
        endcase
      end
      S_PTR: begin
        mem_rd_en = 1'b1;
        mem_rd_addr = ptr_next;
        track_d = ptr_next;
        if (left_q == DEPTH_W'(1)) state_d = S_OPND;
        else left_d = left_q - DEPTH_W'(1);
      end
      S_OPND: begin fin = 1'b1; fin_ea = track_q; fin_op = mem_rd_data; end
      S_STK: begin
        mem_rd_en = 1'b1;
        mem_rd_addr = track_q + W'(1);
        aux_d = mem_rd_data;
        state_d = S_STK2;
      end
      S_STK2: begin
        fin = 1'b1; fin_ea = track_q; fin_op = aux_q; fin_opb = mem_rd_data;
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q <= '0; field_q <= '0; pc_q <= '0; sel_q <= '0;
      track_q <= '0; aux_q <= '0; left_q <= '0; dep_q <= '0; rdcnt_q <= '0;
      done <= 1'b0; err <= 1'b0; ea <= '0; opnd <= '0; opnd_b <= '0;
    end else begin
      state_q <= state_d;
      track_q <= track_d;
      aux_q <= aux_d;
      left_q <= left_d;
      done <= fin;
      err <= fin && fin_err;
      if (fin) begin
        ea <= fin_ea; opnd <= fin_op; opnd_b <= fin_opb;
      end
      if (accept) begin
        mode_q <= req_mode; field_q <= req_field; pc_q <= pc; sel_q <= req_sel;
        dep_q <= eff_depth(req_depth);
        left_q <= (req_mode == M_IND) ? eff_depth(req_depth) : DEPTH_W'(1);
        rdcnt_q <= '0;
      end else if (mem_rd_en) begin
        rdcnt_q <= rdcnt_q + 3'd1;
      end
    end
  end

  // R1: an idle block issues no memory traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_rd_en);
  // R2 and R3: immediate and register forms never touch memory
  a_r2_r3_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CALC && (mode_q == M_IMM || mode_q == M_REG)) |-> !mem_rd_en);
  // R5: pointer chain length matches the requested depth
  a_r5_chain_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_IND) |-> (rdcnt_q == 3'(dep_q) + 3'd1));
  // R8: indexed indirect forms use exactly two reads
  a_r8_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_POST || mode_q == M_PRE || mode_q == M_STK)) |-> (rdcnt_q == 3'd2));
  // R10: error only together with done
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R11: done is a single-cycle pulse that follows a busy cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q != S_IDLE));
endmodule

// File: rtl/operand_locator.sv
`timescale 1ns/1ps
module operand_locator #(
  parameter int W = 16,
  parameter int S = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [3:0]                  req_mode,
  input  logic [W-1:0]                req_field,
  input  logic [S-1:0]                req_sel,
  input  logic [opl_pkg::DEPTH_W-1:0] req_depth,
  input  logic [W-1:0]                pc,
  output logic [S-1:0]                rf_sel,
  input  logic [W-1:0]                rf_data,
  output logic                        mem_rd_en,
  output logic [W-1:0]                mem_rd_addr,
  input  logic [W-1:0]                mem_rd_data,
  output logic                        done,
  output logic                        err,
  output logic [W-1:0]                ea,
  output logic [W-1:0]                opnd,
  output logic [W-1:0]                opnd_b,
  output logic                        idle
);
  logic [3:0]   cur_mode;
  logic [W-1:0] cur_field, cur_pc, first_addr, ptr_next;

  opl_agu #(.W(W)) u_agu (
    .mode(cur_mode), .field(cur_field), .rdat(rf_data), .pc_s(cur_pc),
    .mdat(mem_rd_data), .first_addr(first_addr), .ptr_next(ptr_next)
  );

  opl_ctrl #(.W(W), .S(S)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_field(req_field), .req_sel(req_sel), .req_depth(req_depth), .pc(pc),
    .rf_data(rf_data), .mem_rd_data(mem_rd_data), .first_addr(first_addr),
    .ptr_next(ptr_next), .cur_mode(cur_mode), .cur_field(cur_field),
    .cur_pc(cur_pc), .cur_sel(rf_sel), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .done(done), .err(err), .ea(ea), .opnd(opnd),
    .opnd_b(opnd_b), .idle(idle)
  );
endmodule

// File: tb/operand_locator_test.sv
`timescale 1ns/1ps
module operand_locator_test;
  localparam int W = 16;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_mode = '0;
  logic [W-1:0] req_field = '0;
  logic [S-1:0] req_sel = '0;
  logic [1:0] req_depth = '0;
  logic [W-1:0] pc = '0;
  logic [S-1:0] rf_sel;
  logic [W-1:0] rf_data, mem_rd_addr, mem_rd_data, ea, opnd, opnd_b;
  logic mem_rd_en, done, err, idle;

  logic [W-1:0] mem [0:255];
  logic [W-1:0] regs [0:7];
  logic [W-1:0] mem_q = '0;
  int reads_seen = 0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  operand_locator #(.W(W), .S(S)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_field(req_field), .req_sel(req_sel), .req_depth(req_depth), .pc(pc),
    .rf_sel(rf_sel), .rf_data(rf_data), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .done(done), .err(err),
    .ea(ea), .opnd(opnd), .opnd_b(opnd_b), .idle(idle)
  );

  assign rf_data = regs[rf_sel];
  assign mem_rd_data = mem_q;
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_q <= mem[mem_rd_addr[7:0]];
      reads_seen = reads_seen + 1;
    end
  end

  function automatic logic [W-1:0] rd(input logic [W-1:0] a);
    return mem[a[7:0]];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model of every mode
  task automatic model(input logic [3:0] m, input logic [W-1:0] f, input logic [S-1:0] s,
                       input logic [1:0] d, input logic [W-1:0] pcv,
                       output logic [W-1:0] e, output logic [W-1:0] o,
                       output logic [W-1:0] ob, output bit er, output int nrd);
    logic [W-1:0] p;
    int links;
    e = '0; o = '0; ob = '0; er = 1'b0; nrd = 0;
    case (m)
      4'd0: begin e = f; o = f; end
      4'd1: begin e = f; o = rd(e); nrd = 1; end
      4'd2: begin
        links = (d == 0) ? 1 : int'(d);
        p = f;
        for (int i = 0; i < links; i++) p = rd(p);
        e = p; o = rd(p); nrd = links + 1;
      end
      4'd3: begin e = W'(s); o = regs[s]; end
      4'd4: begin e = regs[s]; o = rd(e); nrd = 1; end
      4'd5: begin e = f + regs[s]; o = rd(e); nrd = 1; end
      4'd6: begin e = f + pcv; o = rd(e); nrd = 1; end
      4'd7: begin e = rd(f) + regs[s]; o = rd(e); nrd = 2; end
      4'd8: begin e = rd(f + regs[s]); o = rd(e); nrd = 2; end
      4'd9: begin e = regs[s]; o = rd(e); ob = rd(e + 16'd1); nrd = 2; end
      default: er = 1'b1;
    endcase
  endtask

  task automatic run(input logic [3:0] m, input logic [W-1:0] f, input logic [S-1:0] s,
                     input logic [1:0] d, input logic [W-1:0] pcv, input bit poke, input string req);
    logic [W-1:0] e, o, ob;
    bit er;
    int nrd, lat, span;
    model(m, f, s, d, pcv, e, o, ob, er, nrd);
    lat = 1 + nrd;
    span = poke ? lat + 3 : lat + 1;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_field = f; req_sel = s; req_depth = d; pc = pcv;
    @(negedge clk);
    reads_seen = 0;
    req_valid = 1'b0;
    pc = pcv ^ 16'h5A5A;
    for (int c = 1; c <= span; c++) begin
      if (poke && c == 1) begin
        req_valid = 1'b1; req_mode = 4'd0; req_field = 16'hDEAD;
      end
      @(posedge clk);
      #1;
      if (poke && c == 1) req_valid = 1'b0;
      check(done == (c == lat), req, "done timing", W'(done), W'(c == lat));
      check(idle == (c >= lat), "R11", "idle", W'(idle), W'(c >= lat));
      if (c == lat) begin
        check(ea == e, req, "ea", ea, e);
        check(opnd == o, req, "operand", opnd, o);
        check(opnd_b == ob, "R9", "second operand", opnd_b, ob);
        check(err == er, "R10", "err", W'(err), W'(er));
        check(reads_seen == nrd, req, "read count", W'(reads_seen), W'(nrd));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = W'((i * 37 + 11) % 256) | 16'h0300;
    for (int i = 0; i < 8; i++) regs[i] = W'(i * 19 + 5);
    regs[6] = 16'h00F8;
    regs[7] = 16'hFFF0;
    repeat (3) @(negedge clk);
    check(!done && !err && idle && !mem_rd_en, "R1", "reset state",
          {12'b0, done, err, idle, mem_rd_en}, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_rd_en && idle, "R1", "quiet after reset", W'(mem_rd_en), 16'h0);

    run(4'd0, 16'h1234, 3'd2, 2'd0, 16'h0000, 1'b0, "R2");
    run(4'd0, 16'hFFFF, 3'd0, 2'd0, 16'h0000, 1'b0, "R2");
    run(4'd3, 16'h0000, 3'd5, 2'd0, 16'h0000, 1'b0, "R3");
    run(4'd1, 16'h0040, 3'd0, 2'd0, 16'h0000, 1'b0, "R4");
    run(4'd2, 16'h0010, 3'd0, 2'd1, 16'h0000, 1'b0, "R5");
    run(4'd2, 16'h0010, 3'd0, 2'd2, 16'h0000, 1'b0, "R5");
    run(4'd2, 16'h0021, 3'd0, 2'd3, 16'h0000, 1'b0, "R5");
    run(4'd2, 16'h0021, 3'd0, 2'd0, 16'h0000, 1'b0, "R5");
    run(4'd4, 16'h0000, 3'd3, 2'd0, 16'h0000, 1'b0, "R6");
    run(4'd5, 16'h0020, 3'd4, 2'd0, 16'h0000, 1'b0, "R7");
    run(4'd5, 16'h0030, 3'd7, 2'd0, 16'h0000, 1'b0, "R7");
    run(4'd6, 16'h0007, 3'd0, 2'd0, 16'hFFFE, 1'b0, "R7");
    run(4'd7, 16'h0005, 3'd6, 2'd0, 16'h0000, 1'b0, "R8");
    run(4'd8, 16'h0005, 3'd6, 2'd0, 16'h0000, 1'b0, "R8");
    run(4'd9, 16'h0000, 3'd2, 2'd0, 16'h0000, 1'b0, "R9");
    run(4'd10, 16'h0044, 3'd1, 2'd3, 16'h0000, 1'b0, "R10");
    run(4'd15, 16'h0044, 3'd1, 2'd3, 16'h0000, 1'b0, "R10");
    run(4'd1, 16'h0099, 3'd0, 2'd0, 16'h0000, 1'b1, "R11");
    run(4'd2, 16'h0033, 3'd0, 2'd3, 16'h0000, 1'b1, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule